// File: doc/BRIEF.md
# Video Sync Frequency Meter

The block times the horizontal and vertical sync signals of an incoming video source against the oscillator clock and publishes the results as two latched count registers. Firmware reads these counts to identify the display mode. Each sync input first passes a glitch filter. A rising-edge detector then drives a measurement counter that runs from a prescaled clock and saturates when it reaches its maximum.

The horizontal measurement spans a fixed number of line periods, 64 by default, and keeps only the upper bits of the counter. With the default parameters the kept value equals two line periods in oscillator clocks. The vertical measurement spans one frame, and its kept upper bits equal the frame period in units of 512 oscillator clocks. While vertical sync is present, the horizontal result is published once per frame. While vertical sync is absent, it is published after every line window. Vertical sync counts as absent once the vertical counter has overflowed without seeing an edge.

Each count has its own overflow flag. A single sticky change interrupt is raised whenever a published value differs from the previous one, or whenever an overflow flag rises. A clear input drops the interrupt.

Top module: `syncFreqMeter`

## Requirements
- R1: A high pulse on either sync input that is seen at only one oscillator clock edge is ignored. It never starts, ends or shortens a measurement.
- R2: For a line period of L clocks, the published horizontal count is floor(H_LINES*L/H_PRE) shifted right by H_CNT_W-H_KEEP. With the defaults (64, 2, 15, 11) this equals 2*L.
- R3: For a frame period of F clocks, the published vertical count is floor(F/V_PRE) shifted right by V_CNT_W-V_KEEP. With the defaults (16, 14, 9) this equals F/512.
- R4: While vertical sync is present, `hCount` changes only at a vertical sync edge. At that edge it takes the most recent completed horizontal window.
- R5: While vertical sync is absent, `hCount` is updated at the end of every horizontal window. Vertical sync becomes absent when the vertical counter overflows, and becomes present again at the next vertical edge.
- R6: When a counter would step past its all-ones value, it stays at all ones and its overflow flag (`hOvf` or `vOvf`) rises at once. A later publish of a measurement that did not overflow clears the flag again.
- R7: `chgIrq` is set, and then stays set, when a publish changes `hCount` or `vCount`, or when `hOvf` or `vOvf` rises.
- R8: A one-cycle `intClr` pulse clears `chgIrq`. Publishing an unchanged value does not set `chgIrq` again.
- R9: After reset, `hCount`, `vCount`, `hOvf`, `vOvf` and `chgIrq` are all zero. No counter runs until the first edge of its own sync input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous reset, active high |
| hsyncIn | input | 1 | Horizontal sync, positive pulses |
| vsyncIn | input | 1 | Vertical sync, positive pulses |
| intClr | input | 1 | Clears the change interrupt |
| hCount | output | H_KEEP (11) | Published horizontal count |
| vCount | output | V_KEEP (9) | Published vertical count |
| hOvf | output | 1 | Horizontal counter overflow flag |
| vOvf | output | 1 | Vertical counter overflow flag |
| chgIrq | output | 1 | Sticky change interrupt |

## Verification
The hardest state to reach is a horizontal result that has been measured but is held back until the next frame edge. To get there, the bench waits for a vertical pulse it generated itself and then changes the line period. It checks that `hCount` keeps the old value until the following frame edge. A second hard case is the loss of vertical sync: the generator is stopped for longer than the vertical counter range, and the bench then confirms that the overflow flag is set and that horizontal updates follow every window. Single-cycle noise pulses are placed at known distances from real pulses, so a missing filter would visibly corrupt a frame measurement.

// File: rtl/syncFreqPkg.sv
package syncFreqPkg;

  // Strobes from the control unit to the measurement datapath
  typedef struct packed {
    logic hRun;      // horizontal counter armed
    logic hRestart;  // first horizontal edge: start without capture
    logic hDone;     // horizontal window complete: capture and restart
    logic vRun;      // vertical counter armed
    logic vRestart;  // first vertical edge: start without capture
    logic vDone;     // frame complete: capture and restart
    logic hPublish;  // copy a horizontal result to the output
    logic vPublish;  // copy the vertical result to the output
    logic present;   // vertical sync is considered present
  } meterStrobes_t;

endpackage

// File: rtl/syncEdgeFilter.sv
module syncEdgeFilter (
  input  logic clk,
  input  logic rst,
  input  logic syncIn,
  output logic rise
);

  logic sampA;
  logic sampB;
  logic level;

  // The filtered level follows the input only after two equal consecutive samples
  always_ff @(posedge clk) begin
    if (rst) begin
      sampA <= 1'b0;
      sampB <= 1'b0;
      level <= 1'b0;
    end else begin
      sampA <= syncIn;
      sampB <= sampA;
      if (sampA == sampB) level <= sampB;
    end
  end

  assign rise = sampA & sampB & ~level;

endmodule

// File: rtl/satCounter.sv
module satCounter #(
  parameter int CNT_W = 15,
  parameter int KEEP  = 11,
  parameter int PRE   = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            run,
  input  logic            restart,
  output logic [KEEP-1:0] capVal,
  output logic            capOvf,
  output logic            ovfEvt
);

  localparam int PW = (PRE > 1) ? $clog2(PRE) : 1;

  logic [PW-1:0]    preCnt;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] nextCnt;
  logic             ovf;
  logic             tick;
  logic             atMax;

  assign tick    = run && (preCnt == PW'(PRE - 1));
  assign atMax   = &cnt;
  assign nextCnt = (tick && !atMax) ? cnt + 1'b1 : cnt;

  // The capture includes the tick of the current cycle, so N clocks give N/PRE
  assign capVal = nextCnt[CNT_W-1 -: KEEP];
  assign capOvf = ovf | (tick & atMax);
  assign ovfEvt = tick & atMax & ~ovf & ~restart;

  always_ff @(posedge clk) begin
    if (rst) begin
      preCnt <= '0;
      cnt    <= '0;
      ovf    <= 1'b0;
    end else if (restart) begin
      preCnt <= '0;
      cnt    <= '0;
      ovf    <= 1'b0;
    end else if (run) begin
      preCnt <= (preCnt == PW'(PRE - 1)) ? '0 : preCnt + 1'b1;
      cnt    <= nextCnt;
      if (tick && atMax) ovf <= 1'b1;
    end
  end

endmodule

// File: rtl/meterCtl.sv
module meterCtl
  import syncFreqPkg::*;
#(
  parameter int H_LINES = 64
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          hRise,
  input  logic          vRise,
  input  logic          vOvfEvt,
  output meterStrobes_t strb
);

  localparam int LW = (H_LINES > 1) ? $clog2(H_LINES) : 1;

  logic [LW-1:0] lineCnt;
  logic          hArmed;
  logic          vArmed;
  logic          present;
  logic          hDoneNow;
  logic          vDoneNow;

  assign hDoneNow = hRise && hArmed && (lineCnt == LW'(H_LINES - 1));
  assign vDoneNow = vRise && vArmed;

  always_comb begin
    strb.hRun     = hArmed;
    strb.hRestart = hRise && !hArmed;
    strb.hDone    = hDoneNow;
    strb.vRun     = vArmed;
    strb.vRestart = vRise && !vArmed;
    strb.vDone    = vDoneNow;
    strb.hPublish = present ? vDoneNow : hDoneNow;
    strb.vPublish = vDoneNow;
    strb.present  = present;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lineCnt <= '0;
      hArmed  <= 1'b0;
      vArmed  <= 1'b0;
      present <= 1'b0;
    end else begin
      if (hRise) begin
        hArmed  <= 1'b1;
        lineCnt <= (!hArmed || hDoneNow) ? '0 : lineCnt + 1'b1;
      end
      if (vRise) begin
        vArmed  <= 1'b1;
        present <= 1'b1;
      end else if (vOvfEvt) begin
        present <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/meterPath.sv
module meterPath
  import syncFreqPkg::*;
#(
  parameter int H_CNT_W = 15,
  parameter int H_KEEP  = 11,
  parameter int H_PRE   = 2,
  parameter int V_CNT_W = 14,
  parameter int V_KEEP  = 9,
  parameter int V_PRE   = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  meterStrobes_t     strb,
  input  logic              intClr,
  output logic [H_KEEP-1:0] hCount,
  output logic [V_KEEP-1:0] vCount,
  output logic              hOvf,
  output logic              vOvf,
  output logic              chgIrq,
  output logic              vOvfEvt
);

  logic [H_KEEP-1:0] hCap, hMeas, hPub, hCountNext;
  logic [V_KEEP-1:0] vCap, vCountNext;
  logic              hCapOvf, hMeasOvf, hPubOvf, hEvt;
  logic              vCapOvf, vEvt;
  logic              hOvfNext, vOvfNext, setIrq;

  satCounter #(.CNT_W(H_CNT_W), .KEEP(H_KEEP), .PRE(H_PRE)) hCounter (
    .clk(clk), .rst(rst), .run(strb.hRun),
    .restart(strb.hRestart | strb.hDone),
    .capVal(hCap), .capOvf(hCapOvf), .ovfEvt(hEvt)
  );

  satCounter #(.CNT_W(V_CNT_W), .KEEP(V_KEEP), .PRE(V_PRE)) vCounter (
    .clk(clk), .rst(rst), .run(strb.vRun),
    .restart(strb.vRestart | strb.vDone),
    .capVal(vCap), .capOvf(vCapOvf), .ovfEvt(vEvt)
  );

  assign vOvfEvt = vEvt;

  // A window finishing in the same cycle takes precedence over the stored one
  assign hPub    = strb.hDone ? hCap : hMeas;
  assign hPubOvf = strb.hDone ? hCapOvf : hMeasOvf;

  always_comb begin
    hCountNext = strb.hPublish ? hPub : hCount;
    hOvfNext   = strb.hPublish ? (hPubOvf | hEvt) : (hOvf | hEvt);
    vCountNext = strb.vPublish ? vCap : vCount;
    vOvfNext   = strb.vPublish ? (vCapOvf | vEvt) : (vOvf | vEvt);
    setIrq     = (hCountNext != hCount) || (vCountNext != vCount) ||
                 (hOvfNext && !hOvf) || (vOvfNext && !vOvf);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hMeas    <= '0;
      hMeasOvf <= 1'b0;
      hCount   <= '0;
      vCount   <= '0;
      hOvf     <= 1'b0;
      vOvf     <= 1'b0;
      chgIrq   <= 1'b0;
    end else begin
      if (strb.hDone) begin
        hMeas    <= hCap;
        hMeasOvf <= hCapOvf;
      end
      hCount <= hCountNext;
      hOvf   <= hOvfNext;
      vCount <= vCountNext;
      vOvf   <= vOvfNext;
      chgIrq <= setIrq | (chgIrq & ~intClr);
    end
  end

endmodule

// File: rtl/syncFreqMeter.sv
module syncFreqMeter
  import syncFreqPkg::*;
#(
  parameter int H_CNT_W = 15,
  parameter int H_KEEP  = 11,
  parameter int H_LINES = 64,
  parameter int H_PRE   = 2,
  parameter int V_CNT_W = 14,
  parameter int V_KEEP  = 9,
  parameter int V_PRE   = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hsyncIn,
  input  logic              vsyncIn,
  input  logic              intClr,
  output logic [H_KEEP-1:0] hCount,
  output logic [V_KEEP-1:0] vCount,
  output logic              hOvf,
  output logic              vOvf,
  output logic              chgIrq
);

  meterStrobes_t strobes;
  logic          hRise;
  logic          vRise;
  logic          vOvfEvt;
  logic          vPresent;

  syncEdgeFilter hFilter (.clk(clk), .rst(rst), .syncIn(hsyncIn), .rise(hRise));
  syncEdgeFilter vFilter (.clk(clk), .rst(rst), .syncIn(vsyncIn), .rise(vRise));

  meterCtl #(.H_LINES(H_LINES)) ctl (
    .clk(clk), .rst(rst), .hRise(hRise), .vRise(vRise),
    .vOvfEvt(vOvfEvt), .strb(strobes)
  );

  meterPath #(
    .H_CNT_W(H_CNT_W), .H_KEEP(H_KEEP), .H_PRE(H_PRE),
    .V_CNT_W(V_CNT_W), .V_KEEP(V_KEEP), .V_PRE(V_PRE)
  ) path (
    .clk(clk), .rst(rst), .strb(strobes), .intClr(intClr),
    .hCount(hCount), .vCount(vCount), .hOvf(hOvf), .vOvf(vOvf),
    .chgIrq(chgIrq), .vOvfEvt(vOvfEvt)
  );

  assign vPresent = strobes.present;

endmodule

// File: rtl/syncFreqMeterChk.sv
module syncFreqMeterChk #(
  parameter int H_KEEP = 11,
  parameter int V_KEEP = 9
) (
  input logic              clk,
  input logic              rst,
  input logic [H_KEEP-1:0] hCount,
  input logic [V_KEEP-1:0] vCount,
  input logic              hOvf,
  input logic              vOvf,
  input logic              chgIrq,
  input logic              intClr,
  input logic              vPresent,
  input logic              vRise
);

  p_reset_state_r9: assert property (@(posedge clk)
    rst |=> (hCount == '0 && vCount == '0 && !hOvf && !vOvf && !chgIrq));

  p_hold_in_frame_r4: assert property (@(posedge clk) disable iff (rst)
    (vPresent && !vRise) |=> $stable(hCount));

  p_hovf_irq_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(hOvf) |-> chgIrq);

  p_vovf_irq_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(vOvf) |-> chgIrq);

  p_change_irq_r7: assert property (@(posedge clk) disable iff (rst)
    (!$stable(hCount) || !$stable(vCount)) |-> chgIrq);

  p_irq_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    (chgIrq && !intClr) |=> chgIrq);

endmodule

bind syncFreqMeter syncFreqMeterChk #(.H_KEEP(H_KEEP), .V_KEEP(V_KEEP)) chk (
  .clk(clk), .rst(rst), .hCount(hCount), .vCount(vCount), .hOvf(hOvf),
  .vOvf(vOvf), .chgIrq(chgIrq), .intClr(intClr), .vPresent(vPresent),
  .vRise(vRise)
);

// File: tb/syncFreqMeter_test.sv
`timescale 1ns/1ps
module syncFreqMeter_test;

  localparam int HL = 8, HP = 2, HW = 10, HK = 8;
  localparam int VP = 4, VW = 10, VK = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic intClr = 1'b0;
  logic hGen = 1'b0, hNoise = 1'b0, vGen = 1'b0, vNoise = 1'b0;
  logic [HK-1:0] hCount;
  logic [VK-1:0] vCount;
  logic hOvf, vOvf, chgIrq;

  int checks = 0, errors = 0;
  bit finished = 0;
  bit hOn = 0, vOn = 0;
  int hPeriod = 50, vPeriod = 1500;
  int hRises = 0, vRises = 0;

  always #2 clk = ~clk;

  syncFreqMeter #(
    .H_CNT_W(HW), .H_KEEP(HK), .H_LINES(HL), .H_PRE(HP),
    .V_CNT_W(VW), .V_KEEP(VK), .V_PRE(VP)
  ) uut (
    .clk(clk), .rst(rst), .hsyncIn(hGen | hNoise), .vsyncIn(vGen | vNoise),
    .intClr(intClr), .hCount(hCount), .vCount(vCount), .hOvf(hOvf),
    .vOvf(vOvf), .chgIrq(chgIrq)
  );

  function automatic int expH(int lineClk);
    return ((HL * lineClk) / HP) >> (HW - HK);
  endfunction

  function automatic int expV(int frameClk);
    return (frameClk / VP) >> (VW - VK);
  endfunction

  task automatic waitClk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic pulseClr();
    intClr = 1'b1;
    waitClk(1);
    intClr = 1'b0;
    waitClk(1);
  endtask

  task automatic endRun();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // Horizontal pulse generator: 3 clocks high, period hPeriod
  initial begin
    forever begin
      if (hOn) begin
        int p;
        p = hPeriod;
        hGen = 1'b1;
        hRises++;
        waitClk(3);
        hGen = 1'b0;
        waitClk(p - 3);
      end else begin
        waitClk(1);
      end
    end
  end

  // Vertical pulse generator: 4 clocks high, period vPeriod
  initial begin
    forever begin
      if (vOn) begin
        int p;
        p = vPeriod;
        vGen = 1'b1;
        vRises++;
        waitClk(4);
        vGen = 1'b0;
        waitClk(p - 4);
      end else begin
        waitClk(1);
      end
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    endRun();
  end

  initial begin
    int snap;
    void'($urandom(32'd4711));
    waitClk(5);
    rst = 1'b0;
    waitClk(2);
    // R9: reset state
    check("R9 hCount", int'(hCount), 0);
    check("R9 vCount", int'(vCount), 0);
    check("R9 flags", int'({hOvf, vOvf, chgIrq}), 0);

    // R5: no vertical sync, horizontal published each window
    hPeriod = 50;
    hOn = 1;
    waitClk(3 * HL * 50 + 50);
    check("R5 hCount absent", int'(hCount), expH(50));
    check("R9 vCount idle", int'(vCount), 0);
    check("R9 vOvf idle", int'(vOvf), 0);

    // R2/R3: both present
    vPeriod = 1500;
    vOn = 1;
    waitClk(3 * 1500 + 2 * HL * 50 + 100);
    check("R2 hCount", int'(hCount), expH(50));
    check("R3 vCount", int'(vCount), expV(1500));

    // R4: horizontal result held until the next frame edge
    vPeriod = 2800;
    waitClk(1500 + 2 * 2800 + 200);
    pulseClr();
    check("R8 irq cleared", int'(chgIrq), 0);
    snap = vRises;
    wait (vRises != snap);
    hPeriod = 100;
    waitClk(2300);
    check("R4 hCount held", int'(hCount), expH(50));
    check("R8 no irq when unchanged", int'(chgIrq), 0);
    snap = vRises;
    wait (vRises != snap);
    waitClk(30);
    check("R4 hCount at frame", int'(hCount), expH(100));
    check("R7 irq on change", int'(chgIrq), 1);

    // R2/R3: random periods
    for (int i = 0; i < 6; i++) begin
      int l, f;
      l = $urandom_range(150, 20);
      f = $urandom_range(2800, 1200);
      hPeriod = l;
      vPeriod = f;
      waitClk(3 * 3000 + 3 * HL * 150);
      check("R2 random hCount", int'(hCount), expH(l));
      check("R3 random vCount", int'(vCount), expV(f));
      check("R6 random no ovf", int'({hOvf, vOvf}), 0);
    end

    // R1: single-clock noise pulses on both inputs
    hPeriod = 60;
    vPeriod = 2000;
    waitClk(3 * 3000 + 3 * HL * 150);
    pulseClr();
    snap = vRises;
    wait (vRises != snap);
    waitClk(1000);
    vNoise = 1'b1;
    waitClk(1);
    vNoise = 1'b0;
    snap = hRises;
    wait (hRises != snap);
    waitClk(30);
    hNoise = 1'b1;
    waitClk(1);
    hNoise = 1'b0;
    waitClk(2 * 2000 + 200);
    check("R1 vCount after noise", int'(vCount), expV(2000));
    check("R1 hCount after noise", int'(hCount), expH(60));
    check("R1 no irq after noise", int'(chgIrq), 0);

    // R6/R5: vertical sync lost
    vOn = 0;
    waitClk(5500);
    check("R6 vOvf set", int'(vOvf), 1);
    check("R7 irq on vOvf", int'(chgIrq), 1);
    hPeriod = 80;
    waitClk(3 * HL * 80 + 100);
    check("R5 hCount continuous", int'(hCount), expH(80));

    // R6: horizontal sync lost, then restored
    hOn = 0;
    waitClk(2700);
    check("R6 hOvf set", int'(hOvf), 1);
    check("R6 hCount kept", int'(hCount), expH(80));
    hPeriod = 70;
    hOn = 1;
    waitClk(4 * HL * 70 + 100);
    check("R6 hOvf cleared", int'(hOvf), 0);
    check("R2 hCount restored", int'(hCount), expH(70));

    // R6/R3: vertical sync restored
    vPeriod = 1600;
    vOn = 1;
    waitClk(3 * 1600 + 100);
    check("R6 vOvf cleared", int'(vOvf), 0);
    check("R3 vCount restored", int'(vCount), expV(1600));
    check("R4 hCount with frames", int'(hCount), expH(70));
    pulseClr();
    check("R8 final clear", int'(chgIrq), 0);

    endRun();
  end

endmodule